// File: doc/BRIEF.md
# Event Frame Counter and Channel Sequencer

This block sits in a data-acquisition event builder. For every outgoing data frame it supplies a 32-bit counter word, and it says which readout channel the next frame belongs to. A run-start strobe opens a run. An event-start strobe (the accepted trigger) opens an event: it loads the channel-enable mask and latches the free-running timestamp. A frame-emitted strobe marks each frame sent. Each such strobe retires one enabled channel, moving upward from the lowest bit index.

The counter word has three formats, chosen by a 2-bit mode input:

- **Per-event index.** A frame count that restarts at 0 on each event.
- **Run count.** A 32-bit frame count that runs for the whole run.
- **Timestamp plus index.** The event's 24-bit timestamp packed above the per-event index.

In the 16-bit mask, bit 2k is the master channel of link pair k and bit 2k+1 is its slave. Only channels whose bit is set produce frames.

Top module: `evb_frame_counter`

## Requirements
- R1: With mode 0 or mode 3, frame_word_o bits 31..8 are zero and bits 7..0 hold the per-event frame index.
- R2: With mode 1, all 32 bits of frame_word_o hold the run frame count.
- R3: With mode 2, bits 31..8 of frame_word_o hold the latched event timestamp and bits 7..0 hold the per-event frame index.
- R4: The per-event frame index becomes 0 on event start or run start, and it rises by one on every accepted frame.
- R5: The run frame count becomes 0 only on run start. It rises by one on every accepted frame and keeps its value across event starts.
- R6: The timestamp is captured from tstamp_i when an event starts and holds for every frame of that event, whatever tstamp_i does afterwards.
- R7: Channel handling works as follows:
  - On event start, the set bits of chan_mask_i become pending.
  - chan_idx_o is the lowest pending bit index and chan_valid_o shows that any channel is pending.
  - Each accepted frame clears that lowest bit, so channels are visited in ascending order, one frame each.
- R8: A frame strobe while no channel is pending is ignored: the index, the count and the channel outputs all stay unchanged. An event with an all-zero mask leaves chan_valid_o low.
- R9: After reset, frame_word_o is 0, chan_valid_o is 0 and chan_idx_o is 0.
- R10: Strobes in the same cycle are resolved in this order:
  - Run start wins over event start and clears all pending channels.
  - Event start wins over a frame strobe, which is then not counted.
- R11: All outputs are registered. A strobe, or a new mode value, sampled at a clock edge is reflected on the outputs right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_start_i | input | 1 | Opens a run; clears the run count, the index and the pending channels |
| event_start_i | input | 1 | Opens an event; loads the mask and latches the timestamp |
| frame_emit_i | input | 1 | One frame has been sent for the current channel |
| chan_mask_i | input | 16 | Channel-enable mask (even bit = master, odd bit = slave) |
| mode_i | input | 2 | Counter word format select |
| tstamp_i | input | 24 | Free-running timestamp |
| frame_word_o | output | 32 | Counter word for the current frame |
| chan_idx_o | output | 4 | Index of the next channel to send |
| chan_valid_o | output | 1 | A channel is still pending in this event |

## Verification
The bench runs through all four mode values and applies a set of masks to each:

- **Full and empty masks.** These separate ordinary stepping from the ignored-strobe case.
- **Alternating master-only and slave-only masks.** These show that the walk skips disabled bits rather than stepping through every index.
- **Both end bits only.** This exposes errors at the two ends of the mask.
- **Every single-bit mask.** This checks the index encoding for each position.

Several events run back to back within one run. This shows that the run count keeps growing while the per-event index restarts. The timestamp input is changed during frames to show that the latched value holds. Strobes are also made to coincide, to pin down the priority order.

// File: rtl/evb_fc_pkg.sv
package evb_fc_pkg;

  // Counter word formats selected by the mode input.
  typedef enum logic [1:0] {
    FMT_EVT   = 2'd0,
    FMT_RUN   = 2'd1,
    FMT_STAMP = 2'd2,
    FMT_ALT   = 2'd3
  } fmt_e;

  // Strobe resolution for one cycle.
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_RUN   = 2'd1,
    ACT_EVENT = 2'd2,
    ACT_FRAME = 2'd3
  } act_e;

endpackage

// File: rtl/evb_lowest_pick.sv
module evb_lowest_pick #(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  onehot_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);

  // Isolate the lowest set bit.
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      if (g == 0) begin : g_first
        assign onehot_o[g] = req_i[g];
      end else begin : g_rest
        assign onehot_o[g] = req_i[g] & ~(|req_i[g-1:0]);
      end
    end
  endgenerate

  // Encode its position.
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IW'(i);
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/evb_chan_walker.sv
module evb_chan_walker
  import evb_fc_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_start_i,
  input  logic            event_start_i,
  input  logic            frame_emit_i,
  input  logic [NCH-1:0]  chan_mask_i,
  output act_e            act_o,
  output logic [CH_W-1:0] chan_idx_o,
  output logic            chan_valid_o
);

  logic [NCH-1:0]  pend_q, pend_n;
  logic [NCH-1:0]  cur_onehot;
  logic [CH_W-1:0] cur_idx;
  logic            cur_any;
  logic [NCH-1:0]  nxt_onehot;
  logic [CH_W-1:0] nxt_idx;
  logic            nxt_any;

  // Lowest pending channel now: the one a frame strobe retires.
  evb_lowest_pick #(.N(NCH), .IW(CH_W)) u_cur (
    .req_i    (pend_q),
    .onehot_o (cur_onehot),
    .idx_o    (cur_idx),
    .any_o    (cur_any)
  );

  // Priority: run start, then event start, then an acceptable frame.
  always_comb begin
    if (run_start_i)                    act_o = ACT_RUN;
    else if (event_start_i)             act_o = ACT_EVENT;
    else if (frame_emit_i && cur_any)   act_o = ACT_FRAME;
    else                                act_o = ACT_NONE;
  end

  always_comb begin
    unique case (act_o)
      ACT_RUN:   pend_n = '0;
      ACT_EVENT: pend_n = chan_mask_i;
      ACT_FRAME: pend_n = pend_q & ~cur_onehot;
      default:   pend_n = pend_q;
    endcase
  end

  // Lowest pending channel after this edge: drives the registered outputs.
  evb_lowest_pick #(.N(NCH), .IW(CH_W)) u_nxt (
    .req_i    (pend_n),
    .onehot_o (nxt_onehot),
    .idx_o    (nxt_idx),
    .any_o    (nxt_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q       <= '0;
      chan_idx_o   <= '0;
      chan_valid_o <= 1'b0;
    end else begin
      pend_q       <= pend_n;
      chan_idx_o   <= nxt_idx;
      chan_valid_o <= nxt_any;
    end
  end

  // R7: each accepted frame retires exactly one pending channel.
  p_one_per_frame_r7: assert property (@(posedge clk) disable iff (rst)
    (act_o == ACT_FRAME) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));

  // R7: the walk moves upward in bit index.
  p_ascending_r7: assert property (@(posedge clk) disable iff (rst)
    (act_o == ACT_FRAME) |=> (!chan_valid_o || (chan_idx_o > $past(chan_idx_o))));

  // R8: a strobe with nothing pending changes nothing.
  p_idle_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    (frame_emit_i && !chan_valid_o && !run_start_i && !event_start_i)
      |=> (!chan_valid_o && $stable(pend_q)));

  // R10: run start empties the pending set.
  p_run_clears_r10: assert property (@(posedge clk) disable iff (rst)
    run_start_i |=> !chan_valid_o);

endmodule

// File: rtl/evb_counters.sv
module evb_counters
  import evb_fc_pkg::*;
#(
  parameter int FOE_W  = 8,
  parameter int WORD_W = 32,
  parameter int TS_W   = WORD_W - FOE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  act_e              act_i,
  input  logic [TS_W-1:0]   tstamp_i,
  output logic [FOE_W-1:0]  foe_n,
  output logic [WORD_W-1:0] gf_n,
  output logic [TS_W-1:0]   ts_n
);

  logic [FOE_W-1:0]  foe_q;
  logic [WORD_W-1:0] gf_q;
  logic [TS_W-1:0]   ts_q;

  always_comb begin
    foe_n = foe_q;
    gf_n  = gf_q;
    ts_n  = ts_q;
    unique case (act_i)
      ACT_RUN: begin
        foe_n = '0;
        gf_n  = '0;
      end
      ACT_EVENT: begin
        foe_n = '0;
        ts_n  = tstamp_i;
      end
      ACT_FRAME: begin
        foe_n = foe_q + 1'b1;
        gf_n  = gf_q + 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      foe_q <= '0;
      gf_q  <= '0;
      ts_q  <= '0;
    end else begin
      foe_q <= foe_n;
      gf_q  <= gf_n;
      ts_q  <= ts_n;
    end
  end

  // R4: the per-event index restarts on an event.
  p_foe_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (act_i == ACT_EVENT) |=> (foe_q == '0));

  // R5: the run count steps by one per accepted frame.
  p_gf_step_r5: assert property (@(posedge clk) disable iff (rst)
    (act_i == ACT_FRAME) |=> (gf_q == $past(gf_q) + 1'b1));

  // R5: event starts and idle cycles leave the run count alone.
  p_gf_hold_r5: assert property (@(posedge clk) disable iff (rst)
    ((act_i == ACT_EVENT) || (act_i == ACT_NONE)) |=> $stable(gf_q));

  // R6: the timestamp moves only at an event start.
  p_ts_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (act_i != ACT_EVENT) |=> $stable(ts_q));

endmodule

// File: rtl/evb_frame_counter.sv
module evb_frame_counter
  import evb_fc_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int FOE_W  = 8,
  parameter int WORD_W = 32,
  localparam int TS_W  = WORD_W - FOE_W,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_start_i,
  input  logic              event_start_i,
  input  logic              frame_emit_i,
  input  logic [NCH-1:0]    chan_mask_i,
  input  logic [1:0]        mode_i,
  input  logic [TS_W-1:0]   tstamp_i,
  output logic [WORD_W-1:0] frame_word_o,
  output logic [CH_W-1:0]   chan_idx_o,
  output logic              chan_valid_o
);

  act_e              act;
  logic [FOE_W-1:0]  foe_n;
  logic [WORD_W-1:0] gf_n;
  logic [TS_W-1:0]   ts_n;
  fmt_e              fmt;

  evb_chan_walker #(.NCH(NCH), .CH_W(CH_W)) u_walk (
    .clk           (clk),
    .rst           (rst),
    .run_start_i   (run_start_i),
    .event_start_i (event_start_i),
    .frame_emit_i  (frame_emit_i),
    .chan_mask_i   (chan_mask_i),
    .act_o         (act),
    .chan_idx_o    (chan_idx_o),
    .chan_valid_o  (chan_valid_o)
  );

  evb_counters #(.FOE_W(FOE_W), .WORD_W(WORD_W), .TS_W(TS_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .act_i    (act),
    .tstamp_i (tstamp_i),
    .foe_n    (foe_n),
    .gf_n     (gf_n),
    .ts_n     (ts_n)
  );

  assign fmt = fmt_e'(mode_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_word_o <= '0;
    end else begin
      unique case (fmt)
        FMT_RUN:   frame_word_o <= gf_n;
        FMT_STAMP: frame_word_o <= {ts_n, foe_n};
        default:   frame_word_o <= {{TS_W{1'b0}}, foe_n};
      endcase
    end
  end

  // R1: per-event format keeps the upper bytes clear.
  p_fmt_evt_r1: assert property (@(posedge clk) disable iff (rst)
    ((mode_i == 2'd0) || (mode_i == 2'd3)) |=> (frame_word_o[WORD_W-1:FOE_W] == '0));

  // R3: stamp format carries the counter's latched stamp.
  p_fmt_stamp_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd2) |=> (frame_word_o[WORD_W-1:FOE_W] == u_cnt.ts_q));

  // R11: an event start shows index 0 right after its edge in index formats.
  p_evt_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (event_start_i && !run_start_i && (mode_i != 2'd1))
      |=> (frame_word_o[FOE_W-1:0] == '0));

endmodule

// File: tb/sim_evb_frame_counter.sv
`timescale 1ns/1ps
module sim_evb_frame_counter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_start_i = 1'b0;
  logic        event_start_i = 1'b0;
  logic        frame_emit_i = 1'b0;
  logic [15:0] chan_mask_i = '0;
  logic [1:0]  mode_i = '0;
  logic [23:0] tstamp_i = '0;
  logic [31:0] frame_word_o;
  logic [3:0]  chan_idx_o;
  logic        chan_valid_o;

  always #2.5 clk = ~clk;

  evb_frame_counter u0 (
    .clk           (clk),
    .rst           (rst),
    .run_start_i   (run_start_i),
    .event_start_i (event_start_i),
    .frame_emit_i  (frame_emit_i),
    .chan_mask_i   (chan_mask_i),
    .mode_i        (mode_i),
    .tstamp_i      (tstamp_i),
    .frame_word_o  (frame_word_o),
    .chan_idx_o    (chan_idx_o),
    .chan_valid_o  (chan_valid_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] m_pend = '0;
  logic [7:0]  m_foe = '0;
  logic [31:0] m_gf = '0;
  logic [23:0] m_ts = '0;
  logic [1:0]  m_mode = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic [31:0] w;
    logic [3:0]  idx;
    string tag;
    case (m_mode)
      2'd1:    begin w = m_gf;            tag = "R2 run-count word"; end
      2'd2:    begin w = {m_ts, m_foe};   tag = "R3 stamp word"; end
      default: begin w = {24'd0, m_foe};  tag = "R1 event-index word"; end
    endcase
    chk(tag, frame_word_o, w);
    idx = '0;
    for (int i = 15; i >= 0; i--) if (m_pend[i]) idx = 4'(i);
    chk("R7 chan_valid", {31'd0, chan_valid_o}, {31'd0, (m_pend != 0)});
    if (m_pend != 0) chk("R7 chan_idx", {28'd0, chan_idx_o}, {28'd0, idx});
  endtask

  // One cycle: drive at negedge, model at posedge, check at next negedge.
  task automatic cyc(input logic rs, input logic es, input logic fe,
                     input logic [15:0] mask, input logic [23:0] ts);
    run_start_i = rs; event_start_i = es; frame_emit_i = fe;
    chan_mask_i = mask; tstamp_i = ts;
    @(posedge clk);
    m_mode = mode_i;
    if (rs) begin
      m_pend = '0; m_foe = '0; m_gf = '0;
    end else if (es) begin
      m_pend = mask; m_foe = '0; m_ts = ts;
    end else if (fe && (m_pend != 0)) begin
      m_pend = m_pend & (m_pend - 16'd1);
      m_foe  = m_foe + 8'd1;
      m_gf   = m_gf + 32'd1;
    end
    @(negedge clk);
    run_start_i = 0; event_start_i = 0; frame_emit_i = 0;
    check_all();
  endtask

  // Full event: start, one frame per enabled channel, then a stray strobe.
  task automatic run_event(input logic [15:0] mask, input logic [23:0] ts);
    logic [31:0] gf_before;
    cyc(0, 1, 0, mask, ts);
    for (int k = 0; k < 17 && m_pend != 0; k++)
      cyc(0, 0, 1, ~mask, ts ^ 24'(k * 24'h010203 + 1));   // R6: stamp input moves
    chk("R6 latched stamp", {8'd0, m_ts}, {8'd0, ts});
    gf_before = m_gf;
    cyc(0, 0, 1, 16'h1234, ts + 24'd7);                    // R8: stray strobe
    chk("R8 count unchanged", m_gf, gf_before);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R9 reset word", frame_word_o, 32'd0);
    chk("R9 reset valid", {31'd0, chan_valid_o}, 32'd0);
    chk("R9 reset idx", {28'd0, chan_idx_o}, 32'd0);

    for (int m = 0; m < 4; m++) begin
      mode_i = 2'(m);
      cyc(0, 0, 0, 16'h0, 24'h0);                          // R11: mode seen next edge
      cyc(1, 0, 0, 16'h0, 24'h0);
      chk("R5 run start clears", m_gf, 32'd0);
      run_event(16'hFFFF, 24'hA00001 + 24'(m));
      run_event(16'h0000, 24'h123456);                     // R8 empty mask
      chk("R8 empty mask no channel", {31'd0, chan_valid_o}, 32'd0);
      run_event(16'h8001, 24'h00FF00);
      run_event(16'h5555, 24'hFFFFFF);
      run_event(16'hAAAA, 24'h0F0F0F);
      for (int b = 0; b < 16; b++) run_event(16'(1 << b), 24'(b * 24'h111111));
      run_event(16'(16'h2468 + m * 16'h1357), 24'hC0FFEE);

      // R10: event start wins over a simultaneous frame strobe.
      cyc(0, 1, 0, 16'h00F0, 24'h000111);
      cyc(0, 0, 1, 16'h0, 24'h0);
      cyc(0, 1, 1, 16'h0C00, 24'h000222);
      chk("R10 event over frame idx", {28'd0, chan_idx_o}, 32'd10);
      chk("R4 index restarts", {24'd0, m_foe}, 32'd0);
      cyc(0, 0, 1, 16'h0, 24'h0);
      // R10: run start wins over event start mid-event.
      cyc(1, 1, 1, 16'hFFFF, 24'h000333);
      chk("R10 run over event", {31'd0, chan_valid_o}, 32'd0);
      cyc(0, 0, 1, 16'h0, 24'h0);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule